// File: doc/BRIEF.md
# LFSR-Based Programmable Clock Divider Chain

The block divides its input clock by programmable integers. It does not use binary counters for the two main dividers. Each main divider is a shift register with linear feedback that steps through a fixed sequence of states. When it reaches the all-ones terminal state, it reloads from a reload input and toggles its divided output.

A 6-bit instance acts as the reference divider and an 8-bit instance acts as the feedback divider. To program a divide ratio N, software writes the sequence state that lies N-1 steps before the terminal state, not the number N. A reload value is used only at a terminal event, so changing it in the middle of a period cannot shorten that period.

Two cascaded post-dividers follow. They are driven by a clock-enable input that stands in for the oscillator clock. Each post-divider is programmed with an inverted 3-bit code.

Each main divider is a two-state machine. PRIME is the state held during reset. On the first clock after reset the divider loads the reload input and makes the transition PRIME to RUN. RUN has two transitions back to itself: *advance* steps the register to its next sequence state, and *terminal reload* loads the reload input and toggles the output.

Top module: `lfsr_clkdiv_chain`

## Requirements
- R1: While `rst_n` is low, all six outputs are 0. After reset is released with reload value R, the first `*_tick` is seen N clock cycles later, where R lies N-1 steps before the terminal state.
- R2: The 6-bit divider steps from state s to {s[4:0], ~(s[5]^s[4])}, except that state 0x00 steps to 0x3f. Its terminal state is 0x3f. Every ratio from 1 to 64 gives a `ref_tick` period of N cycles. Reload 0x3f divides by 1, 0x00 by 2, 0x20 by 3, 0x10 by 4 and 0x01 by 64.
- R3: The 8-bit divider steps from state s to {s[6:0], ~(s[7]^s[3]^s[2]^s[1])}, except that state 0x00 steps to 0xff. Its terminal state is 0xff. Every ratio from 2 to 256 gives an `fb_tick` period of N cycles. Reload 0x00 divides by 2, 0x80 by 3, 0xc0 by 4 and 0x01 by 256.
- R4: `*_tick` is high in each cycle in which the divider holds its terminal state. With a ratio of 1 it stays high continuously. `*_out` inverts in the cycle after each tick and holds its value otherwise.
- R5: The reload input is sampled only at a terminal event. A change in the middle of a period leaves the current period at the old ratio, and the following period uses the new ratio.
- R6: `post_code[5:3]` = 8-pd1 and `post_code[2:0]` = 8-pd2, where pd1 and pd2 are each 1 to 8. With `vco_en` held high, `post_tick` pulses every pd1*pd2 cycles. `post_out` toggles in the same cycle as each `post_tick`. The first `post_tick` after reset is seen one cycle after release.
- R7: A cycle with `vco_en` low does not advance the post-dividers. Holding `vco_en` low keeps `post_tick` at 0 and `post_out` stable. Toggling `vco_en` every cycle doubles the `post_tick` period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_reload | input | 6 | Reload state for the reference divider |
| fb_reload | input | 8 | Reload state for the feedback divider |
| post_code | input | 6 | Inverted post-divider codes, {8-pd1, 8-pd2} |
| vco_en | input | 1 | Clock enable that advances the post-divider chain |
| ref_tick | output | 1 | Reference divider terminal pulse |
| ref_out | output | 1 | Reference divider toggle output |
| fb_tick | output | 1 | Feedback divider terminal pulse |
| fb_out | output | 1 | Feedback divider toggle output |
| post_tick | output | 1 | Registered pulse at the end of each post-divided period |
| post_out | output | 1 | Post-divider toggle output |

## Verification
- **Main dividers.** A divider's tick is decoded from its registered state. The tick is therefore visible in the same cycle as the terminal state, and the toggle output follows one cycle later. The first tick after reset is due N cycles after release, because one extra edge is spent in the PRIME state.
- **Post-dividers.** `post_tick` and `post_out` are both registered. They change one cycle after the enabled terminal cycle.
- **Sampling and interval counting.** All outputs are sampled on the falling clock edge, and every period is counted between two observed ticks.
- **Changing a ratio.** After a new ratio is applied, the bench waits for a tick whose reload edge came after the change, and only then measures.

// File: rtl/lfsr_clkdiv_pkg.sv
package lfsr_clkdiv_pkg;

    typedef enum logic {
        PH_PRIME = 1'b0,
        PH_RUN   = 1'b1
    } div_phase_e;

    localparam int unsigned LFSR_MAX_W = 16;

    // Next state of a shift-left XNOR register of the given width. The
    // all-zero state is routed to all-ones so that the sequence covers
    // every state of the width.
    function automatic logic [LFSR_MAX_W-1:0] lfsr_advance(
        input logic [LFSR_MAX_W-1:0] cur,
        input logic [LFSR_MAX_W-1:0] taps,
        input int unsigned           width
    );
        logic [LFSR_MAX_W-1:0] mask;
        logic                  fb;
        mask = LFSR_MAX_W'((32'd1 << width) - 32'd1);
        fb   = ~(^(cur & taps));
        if ((cur & mask) == '0) begin
            lfsr_advance = mask;
        end else begin
            lfsr_advance = ((cur << 1) | {{(LFSR_MAX_W-1){1'b0}}, fb}) & mask;
        end
    endfunction

endpackage

// File: rtl/lfsr_stage.sv
module lfsr_stage
    import lfsr_clkdiv_pkg::*;
#(
    parameter int unsigned   W    = 6,
    parameter logic [W-1:0]  TAPS = 6'h30
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] reload_i,
    output logic         tick_o,
    output logic         level_o
);

    localparam logic [W-1:0] TERM = {W{1'b1}};

    div_phase_e   phase_q, phase_d;
    logic [W-1:0] state_q, state_d;
    logic [W-1:0] step;
    logic         level_q, level_d;
    logic         at_term;

    assign at_term = (phase_q == PH_RUN) && (state_q == TERM);
    assign step    = W'(lfsr_advance(LFSR_MAX_W'(state_q), LFSR_MAX_W'(TAPS), W));

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_PRIME;
            state_q <= TERM;
            level_q <= 1'b0;
        end else begin
            phase_q <= phase_d;
            state_q <= state_d;
            level_q <= level_d;
        end
    end

    // Next-state logic
    always_comb begin
        phase_d = phase_q;
        state_d = state_q;
        level_d = level_q;
        unique case (phase_q)
            PH_PRIME: begin
                state_d = reload_i;
                phase_d = PH_RUN;
            end
            PH_RUN: begin
                if (at_term) begin
                    state_d = reload_i;
                    level_d = ~level_q;
                end else begin
                    state_d = step;
                end
            end
            default: begin
                phase_d = PH_PRIME;
            end
        endcase
    end

    // Outputs
    always_comb begin
        tick_o  = at_term;
        level_o = level_q;
    end

endmodule

// File: rtl/post_stage.sv
module post_stage #(
    parameter int unsigned PD_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_i,
    input  logic [PD_W-1:0] code_i,
    output logic            tick_o
);

    logic [PD_W-1:0] remain_q;

    assign tick_o = en_i && (remain_q == '0);

    // The divisor is 2**PD_W - code, so the reload count (divisor - 1) is ~code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (en_i) begin
            if (remain_q == '0) begin
                remain_q <= ~code_i;
            end else begin
                remain_q <= remain_q - PD_W'(1);
            end
        end
    end

endmodule

// File: rtl/lfsr_clkdiv_chain.sv
module lfsr_clkdiv_chain #(
    parameter int unsigned           REF_W       = 6,
    parameter logic [REF_W-1:0]      REF_TAPS    = 6'h30,
    parameter int unsigned           FB_W        = 8,
    parameter logic [FB_W-1:0]       FB_TAPS     = 8'h8E,
    parameter int unsigned           PD_W        = 3,
    parameter int unsigned           POST_STAGES = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [REF_W-1:0]              ref_reload,
    input  logic [FB_W-1:0]               fb_reload,
    input  logic [POST_STAGES*PD_W-1:0]   post_code,
    input  logic                          vco_en,
    output logic                          ref_tick,
    output logic                          ref_out,
    output logic                          fb_tick,
    output logic                          fb_out,
    output logic                          post_tick,
    output logic                          post_out
);

    logic [POST_STAGES:0] chain_en;
    logic                 post_tick_q;
    logic                 post_out_q;

    lfsr_stage #(.W(REF_W), .TAPS(REF_TAPS)) u_ref (
        .clk      (clk),
        .rst_n    (rst_n),
        .reload_i (ref_reload),
        .tick_o   (ref_tick),
        .level_o  (ref_out)
    );

    lfsr_stage #(.W(FB_W), .TAPS(FB_TAPS)) u_fb (
        .clk      (clk),
        .rst_n    (rst_n),
        .reload_i (fb_reload),
        .tick_o   (fb_tick),
        .level_o  (fb_out)
    );

    assign chain_en[0] = vco_en;

    // The first stage takes the most significant code field.
    for (genvar g = 0; g < POST_STAGES; g++) begin : g_post
        post_stage #(.PD_W(PD_W)) u_stage (
            .clk    (clk),
            .rst_n  (rst_n),
            .en_i   (chain_en[g]),
            .code_i (post_code[(POST_STAGES-1-g)*PD_W +: PD_W]),
            .tick_o (chain_en[g+1])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            post_tick_q <= 1'b0;
            post_out_q  <= 1'b0;
        end else begin
            post_tick_q <= chain_en[POST_STAGES];
            post_out_q  <= post_out_q ^ chain_en[POST_STAGES];
        end
    end

    assign post_tick = post_tick_q;
    assign post_out  = post_out_q;

endmodule

// File: rtl/lfsr_clkdiv_chain_chk.sv
module lfsr_clkdiv_chain_chk #(
    parameter int unsigned REF_W = 6,
    parameter int unsigned FB_W  = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [REF_W-1:0] ref_reload,
    input logic [FB_W-1:0]  fb_reload,
    input logic             vco_en,
    input logic             ref_tick,
    input logic             ref_out,
    input logic             fb_tick,
    input logic             fb_out,
    input logic             post_tick,
    input logic             post_out
);

    assert_prime_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!ref_tick && !fb_tick));

    assert_div_by_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_tick && ref_reload == '1) |=> ref_tick);

    assert_div_by_two_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_tick && fb_reload == '0) |=> !fb_tick);

    assert_ref_toggle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ref_tick |=> (ref_out != $past(ref_out)));

    assert_ref_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_tick |=> $stable(ref_out));

    assert_fb_toggle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fb_tick |=> (fb_out != $past(fb_out)));

    assert_fb_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !fb_tick |=> $stable(fb_out));

    assert_post_toggle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        post_tick |-> (post_out != $past(post_out)));

    assert_post_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !vco_en |=> (!post_tick && $stable(post_out)));

endmodule

bind lfsr_clkdiv_chain lfsr_clkdiv_chain_chk #(.REF_W(REF_W), .FB_W(FB_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_reload (ref_reload),
    .fb_reload  (fb_reload),
    .vco_en     (vco_en),
    .ref_tick   (ref_tick),
    .ref_out    (ref_out),
    .fb_tick    (fb_tick),
    .fb_out     (fb_out),
    .post_tick  (post_tick),
    .post_out   (post_out)
);

// File: tb/lfsr_clkdiv_chain_bench.sv
`timescale 1ns/1ps
module lfsr_clkdiv_chain_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] ref_reload;
    logic [7:0] fb_reload;
    logic [5:0] post_code;
    logic       vco_en;
    logic       ref_tick, ref_out, fb_tick, fb_out, post_tick, post_out;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    logic [5:0] ref_seq [64];
    logic [7:0] fb_seq  [256];

    always #2 clk = ~clk;

    lfsr_clkdiv_chain u_lfsr_clkdiv_chain (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_reload (ref_reload),
        .fb_reload  (fb_reload),
        .post_code  (post_code),
        .vco_en     (vco_en),
        .ref_tick   (ref_tick),
        .ref_out    (ref_out),
        .fb_tick    (fb_tick),
        .fb_out     (fb_out),
        .post_tick  (post_tick),
        .post_out   (post_out)
    );

    // Sequence rule taken from R2/R3: shift left, XNOR of the tapped bits
    // inserted at bit 0, zero goes to all-ones.
    function automatic int seq_next(int s, int w, int taps);
        int fbit;
        if (s == 0) return (1 << w) - 1;
        fbit = ($countones(s & taps) % 2 == 0) ? 1 : 0;
        return ((s << 1) | fbit) & ((1 << w) - 1);
    endfunction

    function automatic logic tick_of(int which);
        if (which == 0) return ref_tick;
        if (which == 1) return fb_tick;
        return post_tick;
    endfunction

    function automatic logic lvl_of(int which);
        if (which == 0) return ref_out;
        if (which == 1) return fb_out;
        return post_out;
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Wait for one tick, then count the cycles to the next tick.
    task automatic measure(int which, int exp_n, string tag);
        int   c;
        logic prev_l;
        logic l0;
        prev_l = lvl_of(which);
        do begin
            prev_l = lvl_of(which);
            @(negedge clk);
        end while (!tick_of(which));
        l0 = lvl_of(which);
        if (which == 2) begin
            check(l0 != prev_l, {tag, " post_out toggles with tick"}, int'(l0), int'(!prev_l));
        end
        c = 0;
        do begin
            @(negedge clk);
            c++;
            if (c == 1 && which != 2) begin
                check(lvl_of(which) != l0, {tag, " R4 toggle after tick"},
                      int'(lvl_of(which)), int'(!l0));
            end
        end while (!tick_of(which));
        check(c == exp_n, {tag, " period"}, c, exp_n);
    endtask

    task automatic sweep_ref();
        for (int n = 1; n <= 64; n++) begin
            @(negedge clk);
            ref_reload = ref_seq[64 - n];
            measure(0, n, "R2 sweep");
        end
    endtask

    task automatic sweep_fb();
        for (int n = 2; n <= 256; n++) begin
            @(negedge clk);
            fb_reload = fb_seq[256 - n];
            measure(1, n, "R3 sweep");
        end
    endtask

    task automatic sweep_post();
        for (int p1 = 1; p1 <= 8; p1++) begin
            for (int p2 = 1; p2 <= 8; p2++) begin
                @(negedge clk);
                post_code = 6'(((8 - p1) << 3) | (8 - p2));
                measure(2, p1 * p2, "R6 sweep");
            end
        end
    endtask

    initial begin : watchdog
        repeat (180000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin : main
        int   c;
        int   ref_first, fb_first, post_first;
        int   s;
        logic t;
        logic held_out;

        // Build the bench's own reference sequences from the R2/R3 rules.
        s = 1;
        for (int i = 0; i < 64; i++) begin
            ref_seq[i] = 6'(s);
            s = seq_next(s, 6, 'h30);
        end
        s = 1;
        for (int i = 0; i < 256; i++) begin
            fb_seq[i] = 8'(s);
            s = seq_next(s, 8, 'h8E);
        end

        ref_reload = 6'h10;      // divide by 4
        fb_reload  = 8'hc0;      // divide by 4
        post_code  = 6'h35;      // pd1 = 2, pd2 = 3
        vco_en     = 1'b1;
        rst_n      = 1'b0;
        repeat (5) @(negedge clk);
        // R1: quiet outputs in reset
        check({ref_tick, ref_out, fb_tick, fb_out, post_tick, post_out} == 6'b0,
              "R1 outputs in reset",
              int'({ref_tick, ref_out, fb_tick, fb_out, post_tick, post_out}), 0);
        rst_n = 1'b1;
        ref_first = 0;
        fb_first = 0;
        post_first = 0;
        for (int k = 1; k <= 20; k++) begin
            @(negedge clk);
            if (ref_tick && ref_first == 0) ref_first = k;
            if (fb_tick && fb_first == 0) fb_first = k;
            if (post_tick && post_first == 0) post_first = k;
        end
        check(ref_first == 4, "R1 first ref tick", ref_first, 4);
        check(fb_first == 4, "R1 first fb tick", fb_first, 4);
        check(post_first == 1, "R6 first post tick", post_first, 1);

        // R2 stated reload values
        ref_reload = 6'h3f; measure(0, 1,  "R2 reload 0x3f");
        ref_reload = 6'h00; measure(0, 2,  "R2 reload 0x00");
        ref_reload = 6'h20; measure(0, 3,  "R2 reload 0x20");
        ref_reload = 6'h10; measure(0, 4,  "R2 reload 0x10");
        ref_reload = 6'h01; measure(0, 64, "R2 reload 0x01");

        // R3 stated reload values
        fb_reload = 8'h00; measure(1, 2,   "R3 reload 0x00");
        fb_reload = 8'h80; measure(1, 3,   "R3 reload 0x80");
        fb_reload = 8'hc0; measure(1, 4,   "R3 reload 0xc0");
        fb_reload = 8'h01; measure(1, 256, "R3 reload 0x01");

        // Full sweeps of all three dividers running concurrently.
        fork
            sweep_ref();
            sweep_fb();
            sweep_post();
        join

        // R5: reload changed in the middle of a period.
        @(negedge clk);
        fb_reload = fb_seq[256 - 200];
        measure(1, 200, "R5 setup");
        c = 0;
        do begin
            @(negedge clk);
            c++;
            if (c == 20) fb_reload = fb_seq[256 - 3];
        end while (!fb_tick);
        check(c == 200, "R5 period spanning change", c, 200);
        c = 0;
        do begin
            @(negedge clk);
            c++;
        end while (!fb_tick);
        check(c == 3, "R5 period after change", c, 3);

        // R7: gated enable.
        @(negedge clk);
        post_code = 6'h2e;        // pd1 = 3, pd2 = 2
        vco_en = 1'b1;
        measure(2, 6, "R7 setup");
        do begin
            @(negedge clk);
            t = post_tick;
            vco_en = ~vco_en;
        end while (!t);
        c = 0;
        do begin
            @(negedge clk);
            c++;
            t = post_tick;
            vco_en = ~vco_en;
        end while (!t);
        check(c == 12, "R7 alternating enable period", c, 12);
        vco_en = 1'b0;
        @(negedge clk);
        held_out = post_out;
        t = 1'b0;
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            if (post_tick || post_out != held_out) t = 1'b1;
        end
        check(!t, "R7 enable low holds post outputs", int'(t), 0);

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule